// File: doc/BRIEF.md
# LCD Line-Latch Pulse Timing Generator

This block produces the per-line latch pulse for a passive LCD panel, timed purely in system clocks. A free-running line counter defines each line period, whose length comes from a line-cycle register in steps of sixteen clocks. A one-clock strobe marks the first clock of every line. Inside the line, the latch pulse rises after a fixed offset plus a programmable front-porch delay, counted in steps of eight clocks. It then stays high for a programmable width, also in steps of eight clocks.

A width of zero selects tracking. The pulse then follows the valid-data indication from the pixel data path, one clock late to match the registered data. In the alternate mode it also holds high for a fixed number of extra clocks after valid data ends; this is one shift-clock period, set by a parameter. Whatever remains of the line after the pulse is back porch. A pulse that would run past the end of its line is cut off at the line boundary.

A small phase machine orders the pulse within the line. Its states are `LP_FRONT` (counting the porch delay), `LP_HIGH` (fixed-width pulse), `LP_TRACK` (following valid data) and `LP_BACK` (back porch). The transitions are:
- front-done, from `LP_FRONT` to `LP_HIGH` when the width is nonzero, or to `LP_TRACK` when it is zero;
- width-done, from `LP_HIGH` to `LP_BACK`;
- line-wrap, from any state back to `LP_FRONT` on the last clock of the line.

Top module: `lcd_line_pulse_gen`

## Requirements
- R1: While reset is held, `line_pulse` is 0 and the counters sit at the first clock of a line, so `line_start` reads 1.
- R2: The line period is (`line_cycle` + 1) × 16 clocks. `line_start` is high for exactly the first clock of each period and low otherwise.
- R3: With `setup_dly` = d ≥ 1, the pulse rises at clock 14 + 8·d of the line, counting the first clock of the line as clock 0.
- R4: With `setup_dly` = 0, the half-clock extra offset is rounded up, so the pulse rises at clock 15 of the line.
- R5: With `high_wid` = w ≥ 1, the pulse stays high for 8·w clocks.
- R6: The pulse never spans two lines. It is always low at the first clock of a line, and it is cut at the line end if the rise point plus the width exceeds the period. If the rise point lies at or past the end of the line, no pulse occurs.
- R7: With `high_wid` = 0 and `alt_mode` = 0, the pulse at line clock p ≥ rise point equals `data_valid` of the previous clock. Valid data before the clock just ahead of the rise point has no effect.
- R8: With `high_wid` = 0 and `alt_mode` = 1, the pulse additionally stays high for TAIL_CLKS clocks (default 4) after the last clock in which it followed `data_valid` high.
- R9: With `high_wid` ≥ 1, neither `data_valid` nor `alt_mode` changes the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_cycle | input | CYC_W | Line period in units of 16 clocks, minus one |
| setup_dly | input | DLY_W | Front-porch delay in units of 8 clocks |
| high_wid | input | WID_W | Pulse width in units of 8 clocks; 0 selects tracking |
| alt_mode | input | 1 | Alternate mode: extra hold after valid data in tracking |
| data_valid | input | 1 | Valid pixel data is on the data bus this clock |
| line_pulse | output | 1 | Line-latch pulse |
| line_start | output | 1 | High for the first clock of each line |

## Verification
The hardest case to reach is the interplay in tracking mode between the valid-data window, the extra hold of the alternate mode and the line boundary. Valid data that arrives before the rise point, or a hold that would carry into the next line, must both be suppressed. Each scenario drives a cycle-indexed valid-data pattern that is placed relative to the line position. One pattern puts pulses before the porch, inside it, and as a single isolated clock. Another holds valid data high up to the very last clock of the line, so that the extra hold collides with the wrap. Every clock of two full lines is compared against a model built from the history of the stimulus.

// File: rtl/lcd_lp_pkg.sv
`timescale 1ns/1ps
package lcd_lp_pkg;

    typedef enum logic [1:0] {
        LP_FRONT = 2'd0,
        LP_HIGH  = 2'd1,
        LP_TRACK = 2'd2,
        LP_BACK  = 2'd3
    } lp_state_e;

endpackage

// File: rtl/lcd_lp_line_timer.sv
`timescale 1ns/1ps
// Free-running line position counter; period = (line_cycle+1) << LINE_LG2.
module lcd_lp_line_timer #(
    parameter int CYC_W   = 6,
    parameter int LINE_LG2 = 4,
    localparam int POS_W  = CYC_W + LINE_LG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] line_cycle,
    output logic [POS_W-1:0] lpos,
    output logic             line_end,
    output logic             line_first
);

    logic [POS_W-1:0] last_pos;

    // (c + 1) * 2^LINE_LG2 - 1 == {c, all ones}
    assign last_pos   = {line_cycle, {LINE_LG2{1'b1}}};
    assign line_end   = (lpos >= last_pos);
    assign line_first = (lpos == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lpos <= '0;
        end else if (line_end) begin
            lpos <= '0;
        end else begin
            lpos <= lpos + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_lp_porch_calc.sv
`timescale 1ns/1ps
// Converts register settings into terminal counts for the phase machine.
module lcd_lp_porch_calc #(
    parameter int DLY_W      = 4,
    parameter int WID_W      = 4,
    parameter int UNIT_LG2   = 3,
    parameter int OFFSET     = 14,
    parameter bit ROUND_UP   = 1'b1,
    localparam int CNT_W     = ((DLY_W > WID_W) ? DLY_W : WID_W) + UNIT_LG2 + 1
) (
    input  logic [DLY_W-1:0] setup_dly,
    input  logic [WID_W-1:0] high_wid,
    output logic [CNT_W-1:0] front_last,
    output logic [CNT_W-1:0] high_last,
    output logic             track_sel
);

    logic [CNT_W-1:0] dly_span;
    logic [CNT_W-1:0] wid_span;
    logic [CNT_W-1:0] zero_last;

    assign dly_span = CNT_W'(setup_dly) << UNIT_LG2;
    assign wid_span = CNT_W'(high_wid) << UNIT_LG2;

    // Zero delay carries an extra half clock of offset; a single-edge
    // design either rounds it up to a whole clock or drops it.
    generate
        if (ROUND_UP) begin : g_round_up
            assign zero_last = CNT_W'(OFFSET);
        end else begin : g_round_down
            assign zero_last = CNT_W'(OFFSET - 1);
        end
    endgenerate

    always_comb begin
        if (setup_dly == '0) begin
            front_last = zero_last;
        end else begin
            front_last = CNT_W'(OFFSET - 1) + dly_span;
        end
        high_last = wid_span - 1'b1;
        track_sel = (high_wid == '0);
    end

endmodule

// File: rtl/lcd_lp_phase_fsm.sv
`timescale 1ns/1ps
// Orders front porch, pulse and back porch within one line.
module lcd_lp_phase_fsm
    import lcd_lp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_end,
    input  logic [CNT_W-1:0] front_last,
    input  logic [CNT_W-1:0] high_last,
    input  logic             track_sel,
    output lp_state_e        state,
    output logic             in_high,
    output logic             track_en
);

    lp_state_e        state_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt + 1'b1;
        if (line_end) begin
            // line-wrap: every state restarts the porch
            state_nxt = LP_FRONT;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                LP_FRONT: begin
                    if (cnt == front_last) begin
                        // front-done
                        state_nxt = track_sel ? LP_TRACK : LP_HIGH;
                        cnt_nxt   = '0;
                    end
                end
                LP_HIGH: begin
                    if (cnt == high_last) begin
                        // width-done
                        state_nxt = LP_BACK;
                        cnt_nxt   = '0;
                    end
                end
                LP_TRACK: begin
                    cnt_nxt = '0;
                end
                LP_BACK: begin
                    cnt_nxt = '0;
                end
                default: begin
                    state_nxt = LP_FRONT;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LP_FRONT;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        in_high  = (state == LP_HIGH);
        track_en = (state_nxt == LP_TRACK);
    end

endmodule

// File: rtl/lcd_lp_valid_track.sv
`timescale 1ns/1ps
// Zero-width mode: pulse follows registered valid data, with an optional hold.
module lcd_lp_valid_track #(
    parameter int TAIL_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic track_en,
    input  logic alt_mode,
    input  logic data_valid,
    output logic trk_pulse
);

    generate
        if (TAIL_CLKS > 0) begin : g_tail
            localparam int TAIL_W = $clog2(TAIL_CLKS + 1);
            logic [TAIL_W-1:0] tcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tcnt      <= '0;
                    trk_pulse <= 1'b0;
                end else if (!track_en) begin
                    tcnt      <= '0;
                    trk_pulse <= 1'b0;
                end else begin
                    trk_pulse <= data_valid | (alt_mode & (tcnt != '0));
                    if (data_valid) begin
                        tcnt <= TAIL_W'(TAIL_CLKS);
                    end else if (tcnt != '0) begin
                        tcnt <= tcnt - 1'b1;
                    end
                end
            end
        end else begin : g_no_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    trk_pulse <= 1'b0;
                end else begin
                    trk_pulse <= track_en & data_valid;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/lcd_line_pulse_gen.sv
`timescale 1ns/1ps
module lcd_line_pulse_gen
    import lcd_lp_pkg::*;
#(
    parameter int CYC_W     = 6,
    parameter int DLY_W     = 4,
    parameter int WID_W     = 4,
    parameter int LINE_LG2  = 4,
    parameter int UNIT_LG2  = 3,
    parameter int OFFSET    = 14,
    parameter bit ROUND_UP  = 1'b1,
    parameter int TAIL_CLKS = 4,
    localparam int POS_W    = CYC_W + LINE_LG2,
    localparam int CNT_W    = ((DLY_W > WID_W) ? DLY_W : WID_W) + UNIT_LG2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] line_cycle,
    input  logic [DLY_W-1:0] setup_dly,
    input  logic [WID_W-1:0] high_wid,
    input  logic             alt_mode,
    input  logic             data_valid,
    output logic             line_pulse,
    output logic             line_start
);

    logic [POS_W-1:0] lpos;
    logic             line_end;
    logic             line_first;
    logic [CNT_W-1:0] front_last;
    logic [CNT_W-1:0] high_last;
    logic             track_sel;
    lp_state_e        state;
    logic             in_high;
    logic             track_en;
    logic             trk_pulse;

    lcd_lp_line_timer #(
        .CYC_W    (CYC_W),
        .LINE_LG2 (LINE_LG2)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_cycle (line_cycle),
        .lpos       (lpos),
        .line_end   (line_end),
        .line_first (line_first)
    );

    lcd_lp_porch_calc #(
        .DLY_W    (DLY_W),
        .WID_W    (WID_W),
        .UNIT_LG2 (UNIT_LG2),
        .OFFSET   (OFFSET),
        .ROUND_UP (ROUND_UP)
    ) u_calc (
        .setup_dly  (setup_dly),
        .high_wid   (high_wid),
        .front_last (front_last),
        .high_last  (high_last),
        .track_sel  (track_sel)
    );

    lcd_lp_phase_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .front_last (front_last),
        .high_last  (high_last),
        .track_sel  (track_sel),
        .state      (state),
        .in_high    (in_high),
        .track_en   (track_en)
    );

    lcd_lp_valid_track #(
        .TAIL_CLKS (TAIL_CLKS)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .track_en   (track_en),
        .alt_mode   (alt_mode),
        .data_valid (data_valid),
        .trk_pulse  (trk_pulse)
    );

    always_comb begin
        line_start = line_first;
        line_pulse = in_high | trk_pulse;
    end

endmodule

// File: rtl/lcd_lp_checker.sv
`timescale 1ns/1ps
module lcd_lp_checker #(
    parameter int POS_W    = 10,
    parameter int DLY_W    = 4,
    parameter int WID_W    = 4,
    parameter int UNIT_LG2 = 3,
    parameter int OFFSET   = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DLY_W-1:0] setup_dly,
    input logic [WID_W-1:0] high_wid,
    input logic             alt_mode,
    input logic             data_valid,
    input logic             line_pulse,
    input logic             line_start,
    input logic [POS_W-1:0] lpos
);

    logic [15:0] run_len;
    int          rise_at;
    int          width_clks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (line_pulse) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    always_comb begin
        rise_at    = (setup_dly == '0) ? OFFSET + 1
                                       : OFFSET + (int'(setup_dly) << UNIT_LG2);
        width_clks = int'(high_wid) << UNIT_LG2;
    end

    // Line strobe lasts a single clock.
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    // Pulse is never high at the first clock of a line.
    assert_no_pulse_at_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> !line_pulse);

    // Fixed-width pulse rises at offset + delay (covers R4 for zero delay).
    assert_rise_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(line_pulse) && high_wid != '0) |-> (int'(lpos) == rise_at));

    // Fixed-width pulse that ends inside its line has the programmed length.
    assert_fixed_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(line_pulse) && high_wid != '0 && !line_start)
            |-> (int'(run_len) == width_clks));

    // Tracking without hold: pulse only where valid data was high a clock ago.
    assert_track_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && high_wid == '0 && $past(high_wid) == '0 && !$past(alt_mode))
            |-> $past(data_valid));

endmodule

bind lcd_line_pulse_gen lcd_lp_checker #(
    .POS_W    (POS_W),
    .DLY_W    (DLY_W),
    .WID_W    (WID_W),
    .UNIT_LG2 (UNIT_LG2),
    .OFFSET   (OFFSET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .setup_dly  (setup_dly),
    .high_wid   (high_wid),
    .alt_mode   (alt_mode),
    .data_valid (data_valid),
    .line_pulse (line_pulse),
    .line_start (line_start),
    .lpos       (lpos)
);

// File: tb/lcd_line_pulse_gen_tb.sv
`timescale 1ns/1ps
module lcd_line_pulse_gen_tb;

    localparam int CYC_W = 6;
    localparam int DLY_W = 4;
    localparam int WID_W = 4;
    localparam int TAIL  = 4;
    localparam int MAXN  = 400;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CYC_W-1:0] line_cycle = '0;
    logic [DLY_W-1:0] setup_dly = '0;
    logic [WID_W-1:0] high_wid = '0;
    logic             alt_mode = 1'b0;
    logic             data_valid = 1'b0;
    logic             line_pulse;
    logic             line_start;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;
    bit hist [0:MAXN-1];

    always #5 clk = ~clk;

    lcd_line_pulse_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_cycle (line_cycle),
        .setup_dly  (setup_dly),
        .high_wid   (high_wid),
        .alt_mode   (alt_mode),
        .data_valid (data_valid),
        .line_pulse (line_pulse),
        .line_start (line_start)
    );

    task automatic chk(input string req, input string what, input int k,
                       input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d",
                     req, what, k, act, exp);
        end
    endtask

    function automatic bit dv_at(input int pat, input int k, input int len);
        int p = k % len;
        case (pat)
            1:       return (p >= 10 && p <= 12) || (p >= 30 && p < 40) || p == 45;
            2:       return p >= 40;
            3:       return (k % 3) == 0;
            default: return 1'b0;
        endcase
    endfunction

    // Model of the requirements: rise point, width, tracking and hold.
    function automatic int exp_pulse(input int k, input int len, input int dly,
                                     input int wid, input bit alt);
        int p     = k % len;
        int front = (dly == 0) ? 15 : 14 + 8 * dly;
        int lo;
        if (p < front) return 0;
        if (wid != 0) return (p < front + 8 * wid) ? 1 : 0;
        lo = k - 1 - (alt ? TAIL : 0);
        if (lo < k - p + front - 1) lo = k - p + front - 1;
        if (lo < 0) lo = 0;
        for (int j = lo; j <= k - 1; j++) begin
            if (hist[j]) return 1;
        end
        return 0;
    endfunction

    task automatic run_case(input string req, input int cyc, input int dly,
                            input int wid, input bit alt, input int pat);
        int len = (cyc + 1) * 16;
        int n   = 2 * len + 8;
        rst_n      = 1'b0;
        data_valid = 1'b0;
        line_cycle = CYC_W'(cyc);
        setup_dly  = DLY_W'(dly);
        high_wid   = WID_W'(wid);
        alt_mode   = alt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            chk(req, "line_start", k, int'(line_start), ((k % len) == 0) ? 1 : 0);
            chk(req, "line_pulse", k, int'(line_pulse), exp_pulse(k, len, dly, wid, alt));
            hist[k]    = dv_at(pat, k, len);
            data_valid = hist[k];
            @(negedge clk);
        end
    endtask

    // R1: outputs while reset is held, with inputs that would otherwise track.
    task automatic test_reset();
        rst_n      = 1'b0;
        high_wid   = '0;
        data_valid = 1'b1;
        alt_mode   = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "line_pulse", 0, int'(line_pulse), 0);
        chk("R1", "line_start", 0, int'(line_start), 1);
        data_valid = 1'b0;
    endtask

    // R2, R6: 16-clock line shorter than the rise point, so no pulse at all.
    task automatic test_short_line();
        run_case("R2", 0, 1, 1, 1'b0, 0);
    endtask

    // R3, R5, R2: nonzero delay and width in a 64-clock line.
    task automatic test_fixed_pulse();
        run_case("R3", 3, 2, 3, 1'b0, 0);
    endtask

    // R4: zero delay rounds the offset up to 15 clocks.
    task automatic test_zero_delay();
        run_case("R4", 2, 0, 2, 1'b0, 0);
    endtask

    // R6: rise + width past the line end is cut at the boundary.
    task automatic test_clamp();
        run_case("R6", 1, 2, 2, 1'b0, 0);
    endtask

    // R7: zero width follows valid data, early data ignored.
    task automatic test_track();
        run_case("R7", 3, 1, 0, 1'b0, 1);
    endtask

    // R8: alternate mode adds the hold after each valid window.
    task automatic test_track_hold();
        run_case("R8", 3, 1, 0, 1'b1, 1);
    endtask

    // R8, R6: valid data to the last clock; hold must not leak into next line.
    task automatic test_hold_wrap();
        run_case("R8", 2, 1, 0, 1'b1, 2);
    endtask

    // R9: nonzero width ignores toggling valid data and alternate mode.
    task automatic test_fixed_ignores();
        run_case("R9", 3, 1, 2, 1'b1, 3);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_short_line();
        test_fixed_pulse();
        test_zero_delay();
        test_clamp();
        test_track();
        test_track_hold();
        test_hold_wrap();
        test_fixed_ignores();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule